// File: doc/BRIEF.md
# Two-wire serial memory slave engine

This block is the bus-facing half of a 256-byte serial memory. It watches a two-wire clock/data bus, recognises start and stop conditions, and answers only when the byte after a start carries the fixed device type code and the three strap bits of this instance. While addressed it acknowledges bytes, holds the word address counter, passes each written byte to an external write controller, and when reading shifts out bytes from a combinational memory read port for as long as the master keeps acknowledging.

The data line is open drain. The block never drives it high. It only asserts a pull-low enable, and the pad or the board supplies the pull-up. Both bus lines are sampled through synchronisers in a system clock domain that must run at least eight times faster than the bus clock. While the external controller reports a busy write cycle, the engine stays silent.

Top module: `ee_twi_slave`

## Requirements
- R1: A start is the data line falling while the clock line is high. A stop is the data line rising while the clock line is high. Before the first start, no traffic is acknowledged.
- R2: The first byte after a start is the device byte, sent MSB first. Bits 7..4 must equal the type code 4'b1010, bits 3..1 must equal strap_i[2:0], and bit 0 selects read (1) or write (0). On a match the data line is pulled low for the ninth clock. On a mismatch it stays released for the rest of that transaction.
- R3: In a write, the next byte loads the word address counter. Each later byte is acknowledged and appears for one cycle on wr_valid_o, with wr_addr_o equal to the counter and wr_data_o equal to the byte.
- R4: The word address counter advances by one after every data byte written or read, and wraps from 255 to 0.
- R5: In a read, the block drives the byte at rd_addr_o MSB first. Each bit changes only while the clock line is low, and the data line is released during the ninth clock.
- R6: A low sampled on the ninth clock of a read makes the block send the next byte. A high makes it release the data line until the next start.
- R7: A stop that ends a transaction with at least one written data byte pulses commit_o for one cycle. A stop after a read or an empty transaction does not pulse it.
- R8: While wr_busy_i is high, a start is ignored. No device byte is acknowledged and no byte reaches the write port.
- R9: A start seen at any point of a transfer, including in the middle of a byte, restarts the device byte phase. The counter is kept, so a write of the word address followed by a repeated start and a read reads from that address.
- R10: After reset the pull-low enable is off. It changes only while the clock line is low, or at a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Pull data line low when high |
| strap_i | input | 3 | Instance address straps |
| wr_busy_i | input | 1 | Write controller busy with a write cycle |
| rd_addr_o | output | 8 | Read port address (word address counter) |
| rd_data_i | input | 8 | Read port data, combinational from rd_addr_o |
| wr_valid_o | output | 1 | One-cycle pulse per received data byte |
| wr_addr_o | output | 8 | Address of the received data byte |
| wr_data_o | output | 8 | Received data byte |
| commit_o | output | 1 | One-cycle pulse on stop after written bytes |

## Verification
The bench acts as bus master against a behavioural model of memory contents and of the address counter. It aims at the counter wrap during a page write that starts at 0xFE and at a sequential read across the same boundary. A counter that saturates or never wraps would return the wrong bytes there. It also covers a repeated start, both after a word address and in the middle of a byte. A design that keeps the old bit count would then misread the device byte and fail to acknowledge. Device bytes with a wrong strap or type code, and addressing during a busy write cycle, must get no acknowledge and must produce no write or commit pulse. After the master gives no acknowledge, a further clocked byte must read as all ones, which catches a design that keeps transmitting.

// File: rtl/ee_twi_pkg.sv
`timescale 1ns/1ps
package ee_twi_pkg;
  localparam int BYTE_W  = 8;
  localparam int STRAP_W = 3;
  localparam int CNT_W   = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADDR, ST_WADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK, ST_WAIT
  } twi_state_e;
endpackage

// File: rtl/ee_twi_sync_bit.sv
`timescale 1ns/1ps
module ee_twi_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  // bus lines idle high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/ee_twi_cond.sv
`timescale 1ns/1ps
module ee_twi_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // data edge with clock held high on both samples
  assign start_o = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o  = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/ee_twi_fsm.sv
`timescale 1ns/1ps
module ee_twi_fsm
  import ee_twi_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter logic [3:0] TYPE_CODE = 4'b1010
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_s_i,
  input  logic               sda_s_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wr_busy_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic [ADDR_W-1:0]  rd_addr_o,
  output logic               wr_valid_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  output logic               commit_o,
  output logic               sda_oe_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  twi_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              is_read_q, wr_pend_q, m_ack_q;
  logic              dev_match, rx_state, byte_in;

  assign dev_match = (rx_q[BYTE_W-1 -: 4] == TYPE_CODE) && (rx_q[STRAP_W:1] == strap_i);
  assign rx_state  = (state_q == ST_DEV) || (state_q == ST_WADDR) || (state_q == ST_WDATA);
  assign byte_in   = scl_fall_i && (cnt_q == CNT_FULL);
  assign rd_addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      addr_q     <= '0;
      is_read_q  <= 1'b0;
      wr_pend_q  <= 1'b0;
      m_ack_q    <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      commit_o   <= 1'b0;
      sda_oe_o   <= 1'b0;
    end else begin
      wr_valid_o <= 1'b0;
      commit_o   <= 1'b0;
      if (stop_i) begin
        state_q   <= ST_IDLE;
        sda_oe_o  <= 1'b0;
        commit_o  <= wr_pend_q;
        wr_pend_q <= 1'b0;
      end else if (start_i) begin
        sda_oe_o <= 1'b0;
        cnt_q    <= '0;
        state_q  <= wr_busy_i ? ST_IDLE : ST_DEV;
      end else if (rx_state && scl_rise_i && (cnt_q != CNT_FULL)) begin
        rx_q  <= {rx_q[BYTE_W-2:0], sda_s_i};
        cnt_q <= cnt_q + 1'b1;
      end else begin
        unique case (state_q)
          ST_DEV: if (byte_in) begin
            if (dev_match && !wr_busy_i) begin
              state_q   <= ST_DEV_ACK;
              sda_oe_o  <= 1'b1;
              is_read_q <= rx_q[0];
            end else begin
              state_q <= ST_WAIT;
            end
          end
          ST_WADDR: if (byte_in) begin
            addr_q   <= rx_q[ADDR_W-1:0];
            state_q  <= ST_WADDR_ACK;
            sda_oe_o <= 1'b1;
          end
          ST_WDATA: if (byte_in) begin
            wr_valid_o <= 1'b1;
            wr_addr_o  <= addr_q;
            wr_data_o  <= rx_q;
            addr_q     <= addr_q + 1'b1;
            wr_pend_q  <= 1'b1;
            state_q    <= ST_WDATA_ACK;
            sda_oe_o   <= 1'b1;
          end
          ST_DEV_ACK: if (scl_fall_i) begin
            cnt_q <= '0;
            if (is_read_q) begin
              tx_q     <= rd_data_i;
              sda_oe_o <= ~rd_data_i[BYTE_W-1];
              state_q  <= ST_RDATA;
            end else begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_WADDR;
            end
          end
          ST_WADDR_ACK, ST_WDATA_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            cnt_q    <= '0;
            state_q  <= ST_WDATA;
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt_q == CNT_FULL) begin
                sda_oe_o <= 1'b0;
                addr_q   <= addr_q + 1'b1;
                state_q  <= ST_RACK;
              end else begin
                tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              m_ack_q <= ~sda_s_i;
            end else if (scl_fall_i) begin
              if (m_ack_q) begin
                tx_q     <= rd_data_i;
                sda_oe_o <= ~rd_data_i[BYTE_W-1];
                cnt_q    <= '0;
                state_q  <= ST_RDATA;
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  oe_scl_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s_i && $past(scl_s_i) && !$past(start_i || stop_i)) |-> $stable(sda_oe_o));

  // R2
  oe_rise_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall_i));

  // R7
  commit_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(stop_i));

  // R3
  wr_byte_acked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (sda_oe_o && $past(state_q == ST_WDATA)));

  // R8
  busy_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEV && byte_in && wr_busy_i && !stop_i && !start_i) |=> !sda_oe_o);
endmodule

// File: rtl/ee_twi_slave.sv
`timescale 1ns/1ps
module ee_twi_slave
  import ee_twi_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter logic [3:0] TYPE_CODE   = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wr_busy_i,
  output logic [ADDR_W-1:0]  rd_addr_o,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               wr_valid_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  output logic               commit_o
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] line_raw, line_s;
  logic scl_rise, scl_fall, start, stop;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    ee_twi_sync_bit #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (line_raw[g]),
      .q_o   (line_s[g])
    );
  end

  ee_twi_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (line_s[0]),
    .sda_s_i   (line_s[1]),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start),
    .stop_o    (stop)
  );

  ee_twi_fsm #(.ADDR_W(ADDR_W), .TYPE_CODE(TYPE_CODE)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (line_s[0]),
    .sda_s_i   (line_s[1]),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start),
    .stop_i    (stop),
    .strap_i   (strap_i),
    .wr_busy_i (wr_busy_i),
    .rd_data_i (rd_data_i),
    .rd_addr_o (rd_addr_o),
    .wr_valid_o(wr_valid_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .commit_o  (commit_o),
    .sda_oe_o  (sda_oe_o)
  );
endmodule

// File: tb/ee_twi_slave_tb_top.sv
`timescale 1ns/1ps
module ee_twi_slave_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       scl = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic [2:0] strap = 3'b101;
  logic       oe, wr_valid, commit, sda_line;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  logic [7:0] mem [256];
  logic [7:0] model_mem [256];
  logic [15:0] exp_q[$];
  logic [15:0] pend_q[$];
  int checks = 0, fails = 0, commits = 0, busy_cnt = 0, viol = 0;
  logic scl_prev = 1'b1, oe_prev = 1'b0;
  logic [7:0] exp_addr = '0;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~oe;
  assign rd_data  = mem[rd_addr];

  ee_twi_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(oe),
    .strap_i(strap), .wr_busy_i(busy), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .commit_o(commit)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // write controller model and per-clock monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl && scl_prev && (oe !== oe_prev)) viol++;
      scl_prev = scl;
      oe_prev  = oe;
      if (wr_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected write byte", {wr_addr, wr_data}, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk({wr_addr, wr_data} == e, "R3 R4 write byte addr/data", {wr_addr, wr_data}, e);
        end
        pend_q.push_back({wr_addr, wr_data});
      end
      if (commit) begin
        commits++;
        while (pend_q.size() > 0) begin
          logic [15:0] p;
          p = pend_q.pop_front();
          mem[p[15:8]] = p[7:0];
        end
        busy_cnt = 1000;
      end
      if (busy_cnt > 0) busy_cnt--;
      busy = (busy_cnt > 0);
    end
  end

  task automatic half();
    repeat (10) @(negedge clk);
  endtask

  task automatic clock_bit(input logic mb, output logic sb);
    sda_m = mb; half();
    scl = 1'b1; repeat (5) @(negedge clk);
    sb = sda_line; repeat (5) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic start_c();
    sda_m = 1'b1; half();
    scl = 1'b1; half();
    sda_m = 1'b0; half();
    scl = 1'b0;
  endtask

  task automatic stop_c();
    sda_m = 1'b0; half();
    scl = 1'b1; half();
    sda_m = 1'b1; half();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      d[i] = s;
    end
    clock_bit(~mack, s);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    half();
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    int c0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5C;
      model_mem[i] = 8'(i) ^ 8'h5C;
    end
    repeat (5) @(negedge clk);
    chk(oe == 1'b0, "R10 reset pull-low off", oe, 0);
    chk(wr_valid == 1'b0 && commit == 1'b0, "R7 reset no pulses", {wr_valid, commit}, 0);
    rst_n = 1'b1;
    half();

    // R1: full device byte without a start
    scl = 1'b0; half();
    send_byte(8'hAA, ack);
    chk(!ack, "R1 no ack before start", ack, 0);
    scl = 1'b1; half();

    // single byte write
    start_c();
    send_byte(8'hAA, ack); chk(ack, "R2 device write ack", ack, 1);
    send_byte(8'h10, ack); chk(ack, "R3 word address ack", ack, 1);
    exp_q.push_back(16'h105A);
    send_byte(8'h5A, ack); chk(ack, "R3 data ack", ack, 1);
    model_mem[8'h10] = 8'h5A;
    c0 = commits;
    stop_c();
    chk(commits == c0 + 1, "R7 commit after write stop", commits - c0, 1);

    // R8: addressed during busy write cycle
    chk(busy == 1'b1, "R8 controller busy set", busy, 1);
    c0 = commits;
    start_c();
    send_byte(8'hAA, ack); chk(!ack, "R8 no ack while busy", ack, 0);
    send_byte(8'h10, ack); chk(!ack, "R8 no ack on next byte", ack, 0);
    stop_c();
    chk(commits == c0, "R8 no commit while busy", commits - c0, 0);
    wait_idle();

    // R2: strap and type mismatch
    start_c();
    send_byte(8'hA0, ack); chk(!ack, "R2 strap mismatch nack", ack, 0);
    send_byte(8'h55, ack); chk(!ack, "R2 stays released", ack, 0);
    stop_c();
    start_c();
    send_byte(8'hBA, ack); chk(!ack, "R2 type mismatch nack", ack, 0);
    stop_c();
    chk(commits == c0, "R7 no commit on unaddressed", commits - c0, 0);

    // page write across the counter wrap
    start_c();
    send_byte(8'hAA, ack); chk(ack, "R2 device ack page", ack, 1);
    send_byte(8'hFE, ack); chk(ack, "R3 word addr ack page", ack, 1);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] a, v;
      a = 8'hFE + 8'(i);
      v = 8'(8'h11 * (i + 1));
      exp_q.push_back({a, v});
      model_mem[a] = v;
      send_byte(v, ack); chk(ack, "R3 page data ack", ack, 1);
    end
    c0 = commits;
    stop_c();
    chk(commits == c0 + 1, "R7 commit after page", commits - c0, 1);
    wait_idle();

    // random read via repeated start (R9), sequential with wrap (R4 R5 R6)
    start_c();
    send_byte(8'hAA, ack); chk(ack, "R9 device write ack", ack, 1);
    send_byte(8'hFE, ack); chk(ack, "R9 word address ack", ack, 1);
    exp_addr = 8'hFE;
    start_c();
    send_byte(8'hAB, ack); chk(ack, "R9 device read ack after restart", ack, 1);
    for (int k = 0; k < 4; k++) begin
      read_byte(k < 3, d);
      chk(d == model_mem[exp_addr], "R5 R4 sequential read byte", d, model_mem[exp_addr]);
      exp_addr = exp_addr + 8'd1;
    end
    read_byte(1'b0, d);
    chk(d == 8'hFF, "R6 released after master nack", d, 8'hFF);
    c0 = commits;
    stop_c();
    chk(commits == c0, "R7 no commit after read", commits - c0, 0);

    // current address read continues from counter
    start_c();
    send_byte(8'hAB, ack); chk(ack, "R2 device read ack", ack, 1);
    read_byte(1'b0, d);
    chk(d == model_mem[exp_addr], "R4 current address read", d, model_mem[exp_addr]);
    exp_addr = exp_addr + 8'd1;
    stop_c();

    // R9: start in the middle of a byte
    start_c();
    send_byte(8'hAA, ack); chk(ack, "R9 device ack before partial", ack, 1);
    begin
      logic s;
      clock_bit(1'b1, s); clock_bit(1'b0, s); clock_bit(1'b1, s);
    end
    start_c();
    send_byte(8'hAB, ack); chk(ack, "R9 ack after mid-byte start", ack, 1);
    read_byte(1'b0, d);
    chk(d == model_mem[exp_addr], "R9 read after mid-byte start", d, model_mem[exp_addr]);
    stop_c();
    half();

    chk(viol == 0, "R10 pull-low changed while clock high", viol, 0);
    chk(exp_q.size() == 0, "R3 expected write bytes seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule